// File: doc/BRIEF.md
# Split-Nibble Character Bank Mapper

This block selects which 1 KB page of a large character ROM appears in each of the eight 1 KB windows of the 8 KB pattern space seen by the picture processor. The CPU data path into the block is only five bits wide. Each 9-bit page number is therefore held as two separately written halves: a 4-bit low half and a 5-bit high half.

The CPU side gives the block the register group, which is the value of CPU address bits 15..12. Groups 0xB through 0xE belong to this block. The CPU side also gives a 2-bit sub-address that has already been decoded from whichever address lines the board wires, plus five data bits and a write strobe. Each group carries two windows. Sub-addresses 0 and 1 are the low and high halves of the even window. Sub-addresses 2 and 3 are the low and high halves of the odd window. Window index = 2·(group − 0xB) + sub[1].

The picture side presents address bits 12..10. The block returns the page number of the window those bits select, with no clock delay. A write updates its register on the clock edge that samples the strobe.

Top module: `chr_bank_mapper`

## Requirements
- R1: While rst_n is low at a rising clock edge, all sixteen halves clear, so every window reads page 0 afterwards.
- R2: A write with sub-address 0 stores wr_data[3:0] as the low half of window 2·(group − 0xB), and wr_data bit 4 is discarded. Example: a low write of 3 followed by a high write of 1 gives page 0x13.
- R3: A write with sub-address 1 stores wr_data[4:0] as the high half (page bits 8..4) of window 2·(group − 0xB).
- R4: Sub-addresses 2 and 3 store the low and high halves of the odd window 2·(group − 0xB)+1, and any single write loads at most one half.
- R5: Writing one half of a page leaves the other half of that page, and every other window, unchanged.
- R6: With wr_en high, a write whose group lies outside 0xB..0xE changes no window.
- R7: With wr_en low, no window changes, whatever the group, sub-address and data.
- R8: chr_page equals the page of the window chosen by ppu_a[2:0] (0 = $0000 … 7 = $1C00) in the same cycle, with no clock delay.
- R9: A write becomes visible on chr_page only after the clock edge that samples it. During the strobe cycle the old page is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_grp | input | 4 | CPU address bits 15..12 of the write |
| wr_sub | input | 2 | Decoded sub-address within the group |
| wr_data | input | 5 | Write data |
| ppu_a | input | 3 | Picture address bits 12..10 (window select) |
| chr_page | output | 9 | Selected 1 KB character page number |

## Verification
A CPU write and a picture-side read can hit the same window in the same cycle. The bench provokes this by aiming ppu_a at the window being written while the strobe is high, in both directed steps and a long random run. It expects the old page during the strobe cycle and the new page only after the edge. A second overlap is a half write while the other half of that page is being displayed. The bench judges this by comparing chr_page against a behavioural model on every clock.

// File: rtl/chr_bank_pkg.sv
// Shared sizing for the character bank mapper.
// Assumes a 5-bit CPU data path and a 4+5 split of each page number.
package chr_bank_pkg;
    localparam int DATA_W = 5;
    localparam int LO_W   = 4;
    localparam int HI_W   = 5;
    localparam int WIN_N  = 8;
    localparam logic [3:0] GRP_BASE = 4'hB;
endpackage

// File: rtl/chr_half_reg.sv
// One half of a page number: a plain loadable register.
// Assumes ld is a single-cycle decoded strobe; clears on synchronous reset.
module chr_half_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Holds the stored half; loads on strobe, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // Without a strobe the half must keep its value.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
    // A strobed value is visible one cycle later.
    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));
endmodule

// File: rtl/chr_wr_decode.sv
// Turns group, sub-address and strobe into one load strobe per half.
// Assumes two windows per group; sub[1] picks even/odd, sub[0] picks low/high.
module chr_wr_decode #(
    parameter int         WIN_N    = 8,
    parameter logic [3:0] GRP_BASE = 4'hB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_grp,
    input  logic [1:0]       wr_sub,
    output logic [WIN_N-1:0] ld_lo,
    output logic [WIN_N-1:0] ld_hi
);
    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        localparam logic [3:0] GRP_V  = 4'(int'(GRP_BASE) + w / 2);
        localparam logic       ODD_V  = 1'(w % 2);
        logic hit;
        // Matches this window's group and even/odd slot.
        always_comb begin
            hit      = wr_en && (wr_grp == GRP_V) && (wr_sub[1] == ODD_V);
            ld_lo[w] = hit && !wr_sub[0];
            ld_hi[w] = hit &&  wr_sub[0];
        end
    end

    // A single write may touch at most one half.
    assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_hi, ld_lo}));
    // No strobe, no load.
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ({ld_hi, ld_lo} == '0));
endmodule

// File: rtl/chr_page_mux.sv
// Picks one window's page by the picture address bits, combinationally.
// Assumes pages are packed window 0 at the least significant end.
module chr_page_mux #(
    parameter int WIN_N  = 8,
    parameter int PAGE_W = 9,
    localparam int SEL_W = $clog2(WIN_N)
) (
    input  logic [WIN_N*PAGE_W-1:0] pages,
    input  logic [SEL_W-1:0]        sel,
    output logic [PAGE_W-1:0]       page
);
    // Indexed part-select of the chosen window.
    always_comb page = pages[sel*PAGE_W +: PAGE_W];
endmodule

// File: rtl/chr_bank_mapper.sv
// Top: eight 1 KB character windows, each page built from two CPU-written halves.
// Assumes wr_grp is CPU A15..A12 and wr_sub is already decoded from board wiring.
module chr_bank_mapper
    import chr_bank_pkg::*;
#(
    parameter int         P_DATA_W = DATA_W,
    parameter int         P_LO_W   = LO_W,
    parameter int         P_HI_W   = HI_W,
    parameter int         P_WIN_N  = WIN_N,
    parameter logic [3:0] P_BASE   = GRP_BASE,
    localparam int PAGE_W = P_LO_W + P_HI_W,
    localparam int SEL_W  = $clog2(P_WIN_N),
    localparam int GRP_N  = P_WIN_N / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          wr_grp,
    input  logic [1:0]          wr_sub,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]    ppu_a,
    output logic [PAGE_W-1:0]   chr_page
);
    logic [P_WIN_N-1:0]        ld_lo, ld_hi;
    logic [P_WIN_N*PAGE_W-1:0] pages;

    chr_wr_decode #(.WIN_N(P_WIN_N), .GRP_BASE(P_BASE)) i_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_sub(wr_sub), .ld_lo(ld_lo), .ld_hi(ld_hi));

    for (genvar w = 0; w < P_WIN_N; w++) begin : g_page
        logic [P_LO_W-1:0] lo_q;
        logic [P_HI_W-1:0] hi_q;
        chr_half_reg #(.W(P_LO_W)) i_lo (
            .clk(clk), .rst_n(rst_n), .ld(ld_lo[w]),
            .d(wr_data[P_LO_W-1:0]), .q(lo_q));
        chr_half_reg #(.W(P_HI_W)) i_hi (
            .clk(clk), .rst_n(rst_n), .ld(ld_hi[w]),
            .d(wr_data[P_HI_W-1:0]), .q(hi_q));
        // High half forms the upper page bits.
        always_comb pages[w*PAGE_W +: PAGE_W] = {hi_q, lo_q};
    end

    chr_page_mux #(.WIN_N(P_WIN_N), .PAGE_W(PAGE_W)) i_mux (
        .pages(pages), .sel(ppu_a), .page(chr_page));

    // Out-of-range groups leave every page untouched.
    assert_foreign_grp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_grp < P_BASE) || (wr_grp > 4'(int'(P_BASE) + GRP_N - 1))))
        |=> $stable(pages));
    // A cycle after reset every window reads zero.
    assert_cleared_R1: assert property (@(posedge clk)
        !rst_n |=> (chr_page == '0));
endmodule

// File: tb/test_chr_bank_mapper.sv
// Bench: behavioural model of sixteen halves compared with chr_page every clock.
module test_chr_bank_mapper;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_grp = '0;
    logic [1:0] wr_sub = '0;
    logic [4:0] wr_data = '0;
    logic [2:0] ppu_a = '0;
    logic [8:0] chr_page;

    int total = 0;
    int bad = 0;
    int m_lo[8];
    int m_hi[8];

    chr_bank_mapper i_chr_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_sub(wr_sub), .wr_data(wr_data), .ppu_a(ppu_a), .chr_page(chr_page));

    always #(PERIOD/2) clk = ~clk;

    function automatic int model_page(int w);
        return m_hi[w] * 16 + m_lo[w];
    endfunction

    // Drive one cycle, compare before the edge, then commit to the model.
    task automatic step(input logic rst, input logic en, input int grp, input int sub,
                        input int data, input int ppu, input string tag);
        @(negedge clk);
        rst_n = rst; wr_en = en; wr_grp = 4'(grp); wr_sub = 2'(sub);
        wr_data = 5'(data); ppu_a = 3'(ppu);
        #1;
        total++;
        if (rst_n !== 1'b0 || 1) begin
            if (chr_page !== 9'(model_page(ppu))) begin
                bad++;
                $display("FAIL %s: window %0d chr_page=%h expected=%h",
                         tag, ppu, chr_page, model_page(ppu));
            end
        end
        @(posedge clk);
        if (!rst) begin
            for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
        end else if (en && grp >= 11 && grp <= 14) begin
            int w;
            w = (grp - 11) * 2 + sub / 2;
            if (sub % 2 == 0) m_lo[w] = data % 16;
            else              m_hi[w] = data % 32;
        end
    endtask

    task automatic scan(input string tag);
        for (int w = 0; w < 8; w++) step(1, 0, 0, 0, 0, w, tag);
    endtask

    initial begin
        #(PERIOD*200000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, got hang expected end");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 1, 11, 0, 7, 0, "R1");
        scan("R1");
        // Low then high on window 0, read during the write (R9) and after (R2, R3).
        step(1, 1, 11, 0, 3, 0, "R9");
        step(1, 1, 11, 1, 1, 0, "R9");
        step(1, 0, 0, 0, 0, 0, "R2");
        // Bit 4 dropped on a low write.
        step(1, 1, 11, 0, 31, 0, "R2");
        step(1, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 11, 1, 22, 0, "R3");
        step(1, 0, 0, 0, 0, 0, "R3");
        // Odd windows through sub-addresses 2 and 3.
        step(1, 1, 12, 2, 10, 3, "R4");
        step(1, 1, 12, 3, 21, 3, "R4");
        step(1, 1, 14, 3, 9, 7, "R4");
        step(1, 1, 13, 2, 5, 5, "R4");
        scan("R4");
        // One half only: the other half and neighbours stay.
        step(1, 1, 12, 2, 1, 3, "R5");
        step(1, 1, 13, 1, 2, 4, "R5");
        scan("R5");
        // Groups outside range, strobe high.
        step(1, 1, 9, 0, 31, 0, "R6");
        step(1, 1, 10, 1, 31, 0, "R6");
        step(1, 1, 15, 3, 31, 7, "R6");
        step(1, 1, 0, 2, 31, 1, "R6");
        scan("R6");
        // In-range writes with strobe low.
        step(1, 0, 11, 0, 15, 0, "R7");
        step(1, 0, 14, 3, 31, 7, "R7");
        scan("R7");
        // Random traffic, including reads of the window being written.
        for (int k = 0; k < 400; k++)
            step(1, 1'($urandom_range(0, 1)), $urandom_range(9, 15),
                 $urandom_range(0, 3), $urandom_range(0, 31),
                 $urandom_range(0, 7), "R8");
        // Mid-run reset.
        step(0, 0, 0, 0, 0, 2, "R1");
        scan("R1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule